// File: doc/BRIEF.md
# Isolated Gate Pulse Decoder

This block rebuilds two gate-drive levels on the receive side of an isolation barrier. Channel A and channel B each carry one-cycle set and clear strobes. Each channel holds its level in a bistable state element. A per-channel watchdog pulls the level low, and flags a fault, when strobes stop arriving for a configurable number of clock cycles. A transmitter that refreshes its level periodically therefore keeps the channel alive. If the transmitter loses power, the channel falls to a safe low drive.

Two conditions act on the output side. An undervoltage-ok flag holds both drives low and discards the decoded state while it is deasserted. A strapped interlock input, when set, turns the case where both decoded levels are high into both drives low. Every other combination passes through unchanged. Both channels use the same register path, so simultaneous inputs give simultaneous outputs.

Top module: `gate_pulse_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both drives are 0 and both fault flags are 1. Reset leaves the watchdogs expired.
- R2: A set strobe alone on a channel (set=1, clear=0) is sampled at clock edge k, and that channel's drive is 1 after edge k+1. The level then holds with no further strobes until the watchdog limit is reached.
- R3: A clear strobe alone (clear=1, set=0) drives that channel to 0 with the same two-edge latency.
- R4: Every valid strobe (set alone or clear alone) restarts the watchdog. If no valid strobe arrives for WDOG_CYCLES edges after the last one, the state is cleared at edge k+WDOG_CYCLES. The drive then goes to 0 and the fault flag goes to 1 after edge k+WDOG_CYCLES+1. Valid strobes spaced WDOG_CYCLES-1 edges apart keep the drive high.
- R5: A fault flag stays 1 until the next valid strobe on its channel. Both a set strobe and a clear strobe return it to 0 with the two-edge latency.
- R6: Set and clear together on one channel in the same cycle count as an invalid strobe. The level, the fault flag and the watchdog count all hold for that cycle, so a trip that was pending arrives one edge later than it would have.
- R7: With uv_ok at 0 at an edge, both drives are 0 and both fault flags are 1 after that edge. Both channel states are cleared and both watchdogs are expired, and strobes are discarded while uv_ok is 0.
- R8: With ilk_en at 1, decoded levels A=1 and B=1 give drive_a=0 and drive_b=0. The patterns 10 and 01 pass through unchanged. A change of ilk_en takes effect on the drives after one edge.
- R9: With ilk_en at 0, each drive follows its own decoded level, and both drives may be 1 together.
- R10: After a watchdog trip, or after uv_ok returns to 1, the drives stay 0 until a new valid strobe arrives. One set strobe then restores the drive with the normal two-edge latency.
- R11: Set strobes on both channels in the same cycle make both drives rise after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_a | input | 1 | Channel A set strobe |
| clr_a | input | 1 | Channel A clear strobe |
| set_b | input | 1 | Channel B set strobe |
| clr_b | input | 1 | Channel B clear strobe |
| uv_ok | input | 1 | Output-side supply good; 0 forces safe state |
| ilk_en | input | 1 | Strap: 1 enables the both-high interlock |
| drive_a | output | 1 | Registered gate drive, channel A |
| drive_b | output | 1 | Registered gate drive, channel B |
| fault_a | output | 1 | Channel A watchdog / safe-state flag |
| fault_b | output | 1 | Channel B watchdog / safe-state flag |

## Verification
The bench finds the exact edge at which the watchdog trips, with a silent channel and with one that carries an invalid strobe part-way through the window. A counter that trips one cycle early or late, or one that keeps counting through an invalid strobe, fails at that cycle. A simultaneous set-and-clear is also sent to a faulted channel; a design that treats it as a real strobe would clear the fault. The bench cycles the interlock strap with both levels high and checks the single-high patterns, which catches an interlock that blocks one channel too many. It also pulls uv_ok low and checks that the drives come back only after a fresh strobe, which catches a design that freezes its state instead of discarding it.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    STROBE_NONE  = 2'd0,
    STROBE_SET   = 2'd1,
    STROBE_CLR   = 2'd2,
    STROBE_BAD   = 2'd3
  } strobe_kind_t;

  typedef logic [NUM_CH-1:0] ch_vec_t;

  function automatic strobe_kind_t classify(input logic s, input logic c);
    if (s && c)  return STROBE_BAD;
    else if (s)  return STROBE_SET;
    else if (c)  return STROBE_CLR;
    else         return STROBE_NONE;
  endfunction
endpackage

// File: rtl/gpd_chan_decoder.sv
module gpd_chan_decoder
  import gpd_pkg::*;
#(
  parameter int WDOG_CYCLES = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_ok,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o,
  output logic fault_o
);
  localparam int CW = $clog2(WDOG_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WDOG_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(WDOG_CYCLES - 1);

  strobe_kind_t kind;
  logic [CW-1:0] quiet_cnt;

  assign kind = classify(set_i, clr_i);

  always_ff @(posedge clk) begin
    if (rst || !uv_ok) begin
      level_o   <= 1'b0;
      fault_o   <= 1'b1;
      quiet_cnt <= LIMIT;
    end else begin
      case (kind)
        STROBE_SET: begin
          level_o   <= 1'b1;
          fault_o   <= 1'b0;
          quiet_cnt <= '0;
        end
        STROBE_CLR: begin
          level_o   <= 1'b0;
          fault_o   <= 1'b0;
          quiet_cnt <= '0;
        end
        STROBE_BAD: begin
          // invalid strobe: everything holds
          level_o   <= level_o;
          fault_o   <= fault_o;
          quiet_cnt <= quiet_cnt;
        end
        default: begin
          if (quiet_cnt < LIMIT) begin
            quiet_cnt <= quiet_cnt + 1'b1;
            if (quiet_cnt == LAST) begin
              level_o <= 1'b0;
              fault_o <= 1'b1;
            end
          end else begin
            level_o <= 1'b0;
            fault_o <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gpd_drive_stage.sv
module gpd_drive_stage
  import gpd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    uv_ok,
  input  logic    ilk_en,
  input  ch_vec_t level_i,
  input  ch_vec_t fault_i,
  output ch_vec_t drive_o,
  output ch_vec_t fault_o
);
  ch_vec_t gated;
  ch_vec_t next_drive;

  always_comb begin
    gated = level_i & {NUM_CH{uv_ok}};
    if (ilk_en && (&gated)) next_drive = '0;
    else                    next_drive = gated;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o <= '0;
      fault_o <= '1;
    end else begin
      drive_o <= next_drive;
      fault_o <= fault_i | {NUM_CH{~uv_ok}};
    end
  end
endmodule

// File: rtl/gate_pulse_decoder.sv
module gate_pulse_decoder
  import gpd_pkg::*;
#(
  parameter int WDOG_CYCLES = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic set_a,
  input  logic clr_a,
  input  logic set_b,
  input  logic clr_b,
  input  logic uv_ok,
  input  logic ilk_en,
  output logic drive_a,
  output logic drive_b,
  output logic fault_a,
  output logic fault_b
);
  ch_vec_t set_v, clr_v, level_v, fault_v, drive_v, flag_v;

  assign set_v = {set_b, set_a};
  assign clr_v = {clr_b, clr_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gpd_chan_decoder #(.WDOG_CYCLES(WDOG_CYCLES)) u_dec (
      .clk     (clk),
      .rst     (rst),
      .uv_ok   (uv_ok),
      .set_i   (set_v[ch]),
      .clr_i   (clr_v[ch]),
      .level_o (level_v[ch]),
      .fault_o (fault_v[ch])
    );
  end

  gpd_drive_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .uv_ok   (uv_ok),
    .ilk_en  (ilk_en),
    .level_i (level_v),
    .fault_i (fault_v),
    .drive_o (drive_v),
    .fault_o (flag_v)
  );

  assign drive_a = drive_v[0];
  assign drive_b = drive_v[1];
  assign fault_a = flag_v[0];
  assign fault_b = flag_v[1];
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker (
  input logic clk,
  input logic rst,
  input logic set_a,
  input logic clr_a,
  input logic set_b,
  input logic clr_b,
  input logic uv_ok,
  input logic ilk_en,
  input logic drive_a,
  input logic drive_b,
  input logic fault_a,
  input logic fault_b
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R8: interlock never lets both drives be high
  assert_interlock_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && drive_a && drive_b) |-> !$past(ilk_en));

  // R7: a high drive requires supply ok on the previous edge
  assert_uv_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && (drive_a || drive_b)) |-> $past(uv_ok));

  // R4: a faulted channel never drives high
  assert_fault_low_a_R4: assert property (@(posedge clk) disable iff (rst)
    fault_a |-> !drive_a);
  assert_fault_low_b_R4: assert property (@(posedge clk) disable iff (rst)
    fault_b |-> !drive_b);

  // R2: lone set strobe gives a high drive two edges later
  assert_set_latency_a_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(set_a && !clr_a, 2) && $past(uv_ok, 2)
      && $past(uv_ok) && !$past(ilk_en)) |-> drive_a);
  assert_set_latency_b_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(set_b && !clr_b, 2) && $past(uv_ok, 2)
      && $past(uv_ok) && !$past(ilk_en)) |-> drive_b);
endmodule

bind gate_pulse_decoder gpd_checker u_gpd_checker (
  .clk(clk), .rst(rst), .set_a(set_a), .clr_a(clr_a), .set_b(set_b),
  .clr_b(clr_b), .uv_ok(uv_ok), .ilk_en(ilk_en), .drive_a(drive_a),
  .drive_b(drive_b), .fault_a(fault_a), .fault_b(fault_b)
);

// File: tb/tb_gate_pulse_decoder.sv
`timescale 1ns/1ps
module tb_gate_pulse_decoder;
  localparam int WD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_a = 0, clr_a = 0, set_b = 0, clr_b = 0;
  logic uv_ok = 1'b1, ilk_en = 1'b0;
  logic drive_a, drive_b, fault_a, fault_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  gate_pulse_decoder #(.WDOG_CYCLES(WD)) dut (
    .clk(clk), .rst(rst), .set_a(set_a), .clr_a(clr_a), .set_b(set_b),
    .clr_b(clr_b), .uv_ok(uv_ok), .ilk_en(ilk_en), .drive_a(drive_a),
    .drive_b(drive_b), .fault_a(fault_a), .fault_b(fault_b)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {drv_b,drv_a,flt_b,flt_a} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {drive_b, drive_a, fault_b, fault_a};
  endfunction

  // raise strobes at a negedge, sampled at the next posedge, dropped after it
  task automatic strobe(input logic sa, input logic ca, input logic sb, input logic cb);
    set_a = sa; clr_a = ca; set_b = sb; clr_b = cb;
    @(negedge clk);
    set_a = 0; clr_a = 0; set_b = 0; clr_b = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 4'b0011);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", outs(), 4'b0011);
    strobe(1, 1, 0, 0);              // invalid strobe on faulted channel
    @(negedge clk);
    check("R6 bad strobe keeps fault", outs(), 4'b0011);
  endtask

  task automatic t_set_clear();
    strobe(1, 0, 0, 0);
    check("R2 not yet after one edge", outs(), 4'b0011);
    @(negedge clk);
    check("R2 set drives A high, R5 fault cleared", outs(), 4'b0110);
    repeat (3) @(negedge clk);
    check("R2 level held", outs(), 4'b0110);
    strobe(0, 1, 0, 0);
    @(negedge clk);
    check("R3 clear drives A low", outs(), 4'b0010);
    strobe(0, 0, 0, 1);
    @(negedge clk);
    check("R5 clear strobe clears fault B", outs(), 4'b0000);
  endtask

  task automatic t_watchdog();
    strobe(1, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      repeat (WD - 2) @(negedge clk);
      strobe(1, 0, 1, 0);
    end
    @(negedge clk);
    check("R4 keepalive holds both high", outs(), 4'b1100);
    // now silent: last strobe at edge k, we are after k+1
    repeat (WD - 1) @(negedge clk);
    check("R4 still high after k+WD", outs(), 4'b1100);
    @(negedge clk);
    check("R4 trip after k+WD+1", outs(), 4'b0011);
    repeat (5) @(negedge clk);
    check("R5 fault persists", outs(), 4'b0011);
    strobe(1, 0, 0, 0);
    @(negedge clk);
    check("R10 recover A after trip", outs(), 4'b0110);
  endtask

  task automatic t_invalid();
    strobe(0, 1, 0, 1);
    strobe(1, 0, 1, 0);             // set both at edge k, now after k
    repeat (2) @(negedge clk);      // after k+2
    strobe(0, 0, 1, 1);             // bad on B sampled at k+3, now after k+3
    @(negedge clk);
    check("R6 bad strobe keeps B high", outs(), 4'b1100);
    repeat (WD - 4) @(negedge clk); // after k+WD
    check("R4 A high after k+WD", outs(), 4'b1100);
    @(negedge clk);                 // after k+WD+1
    check("R6 B trips one edge late", outs(), 4'b1001);
    @(negedge clk);                 // after k+WD+2
    check("R6 B trips after hold", outs(), 4'b0011);
  endtask

  task automatic t_interlock();
    ilk_en = 1'b0;
    strobe(1, 0, 1, 0);
    check("R11 neither yet", outs(), 4'b0011);
    @(negedge clk);
    check("R11 both rise together, R9 both high", outs(), 4'b1100);
    ilk_en = 1'b1;
    @(negedge clk);
    check("R8 both high blocked", outs(), 4'b0000);
    ilk_en = 1'b0;
    @(negedge clk);
    check("R9 strap off passes both", outs(), 4'b1100);
    ilk_en = 1'b1;
    strobe(0, 0, 0, 1);
    @(negedge clk);
    check("R8 pattern 10 passes", outs(), 4'b0100);
    strobe(0, 1, 1, 0);
    @(negedge clk);
    check("R8 pattern 01 passes", outs(), 4'b1000);
    ilk_en = 1'b0;
  endtask

  task automatic t_uv();
    strobe(1, 0, 1, 0);
    @(negedge clk);
    check("R9 both high before uv", outs(), 4'b1100);
    uv_ok = 1'b0;
    @(negedge clk);
    check("R7 uv low forces safe", outs(), 4'b0011);
    strobe(1, 0, 1, 0);
    @(negedge clk);
    check("R7 strobes ignored in uv", outs(), 4'b0011);
    uv_ok = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 state discarded after uv", outs(), 4'b0011);
    strobe(1, 0, 0, 0);
    @(negedge clk);
    check("R10 recover after uv", outs(), 4'b0110);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_watchdog();
    t_invalid();
    t_interlock();
    t_uv();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: bench hung, actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule